// File: doc/BRIEF.md
# Weighted Set-Based Channel Arbiter

This block chooses which of 32 DMA channels the shared transfer engine serves next. The channels fall into four sets. Each set is made of two interleaved groups of four channels, and set 0 carries the most weight. The arbiter walks a repeating frame of eight service slots. When every set is asking for service, set 0 wins four slots of the frame, set 1 wins two, and sets 2 and 3 win one each. Inside a set, the eight member channels take turns in round-robin order.

The engine sees a registered grant: a one-hot vector, the channel number and a valid flag. The grant holds until the engine pulses the accept strobe. Accepting a grant moves the slot pointer forward by one and moves the granted set's round-robin pointer past the served member. If the granted channel withdraws its request first, the grant is dropped and nothing advances. The engine accepts at most one grant every two cycles.

Top module: `slot_set_arbiter`

## Requirements
- R1: Channel c belongs to set (c / 4) mod 4, so set s owns channels 4s..4s+3 and 16+4s..16+4s+3.
- R2: The frame slots are owned by sets 0,1,0,2,0,1,0,3 in that order. The slot pointer advances by one, wrapping after slot 7, only on an accepted grant. With all channels requesting, 32 accepted grants therefore give set 0, set 1, set 2 and set 3 the counts 16, 8, 4 and 4.
- R3: If the set that owns the current slot has no requesting channel, the grant goes to the lowest-numbered set that has one.
- R4: Member m (0..7) of set s is channel 4s+m for m<4 and 16+4s+(m-4) for m≥4. The search inside a set starts at the member just after the one last accepted in that set, wraps after member 7, and takes the first requesting member it finds.
- R5: When no grant is held and some channel requests, the grant appears one clock later. It then keeps the same channel while the request stays up and no accept arrives.
- R6: An accept with a grant held clears the valid flag on the next clock. An accept with no grant held changes no pointer.
- R7: If the granted channel drops its request before the grant is accepted, the valid flag clears on the next clock and no pointer advances.
- R8: After reset the grant is deasserted and all pointers are zero. The first grant with all channels requesting is therefore channel 0.
- R9: grantVec is all zero when grantValid is low. Otherwise it has exactly one bit set, at position grantIdx.
- R10: No cycle is left idle. Whenever no grant is held and any request is high, a grant is valid on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanReq | input | 32 | One request bit per channel |
| grantAccept | input | 1 | Engine takes the held grant |
| grantVec | output | 32 | One-hot grant |
| grantIdx | output | 5 | Granted channel number |
| grantValid | output | 1 | A grant is held |

## Verification
A wrong slot pointer shows up at the ports on the very next grant, because a different set wins when everything is requesting. A wrong round-robin pointer shows up on the next grant given to that set, as a repeated or skipped member. The bench keeps its own model of the slot and round-robin pointers. It compares every grant against that model over full-load runs, single-set runs and several hundred sparse request patterns that force the fallback path. Any drift in a pointer therefore shows as a mismatch within one frame.

// File: rtl/sarb_pkg.sv
package sarb_pkg;
  // Strobes sent from the control FSM to the datapath
  typedef struct packed {
    logic loadGrant;    // capture a new winner into the grant registers
    logic commitGrant;  // held grant was accepted: advance the round-robin state
  } sarb_strobe_t;
endpackage

// File: rtl/sarb_ctrl.sv
module sarb_ctrl
  import sarb_pkg::*;
#(
  parameter int NUM_SETS = 4,
  localparam int SET_W  = $clog2(NUM_SETS),
  localparam int SLOT_W = NUM_SETS - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             anyReq,
  input  logic             heldReq,
  input  logic             grantAccept,
  output sarb_strobe_t     strobe,
  output logic             grantValid,
  output logic [SET_W-1:0] ownerSet
);

  logic              validQ;
  logic [SLOT_W-1:0] slotQ;

  // The owner of a slot is the number of trailing ones in the slot number,
  // which gives 0,1,0,2,0,1,0,3 for an 8-slot frame.
  always_comb begin
    logic stop;
    ownerSet = '0;
    stop     = 1'b0;
    for (int i = 0; i < SLOT_W; i++) begin
      if (!stop) begin
        if (slotQ[i]) ownerSet = ownerSet + 1'b1;
        else          stop     = 1'b1;
      end
    end
  end

  always_comb begin
    strobe.loadGrant   = !validQ && anyReq;
    strobe.commitGrant = validQ && grantAccept;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      slotQ  <= '0;
    end else if (strobe.loadGrant) begin
      validQ <= 1'b1;
    end else if (strobe.commitGrant) begin
      validQ <= 1'b0;
      slotQ  <= slotQ + 1'b1;
    end else if (validQ && !heldReq) begin
      validQ <= 1'b0;
    end
  end

  assign grantValid = validQ;

  // R10: no idle cycle while anything requests
  p_no_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!validQ && anyReq) |=> validQ);

  // R6: an accepted grant is released on the next clock
  p_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && grantAccept) |=> !validQ);

  // R2: the slot pointer only moves on a cycle in which a grant was held and accepted
  p_slot_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(validQ && grantAccept) |=> $stable(slotQ));

endmodule

// File: rtl/sarb_path.sv
module sarb_path
  import sarb_pkg::*;
#(
  parameter int NUM_CH   = 32,
  parameter int NUM_SETS = 4,
  parameter int GROUP    = 4,
  localparam int MEMBERS = NUM_CH / NUM_SETS,
  localparam int MEM_W   = $clog2(MEMBERS),
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int IDX_W   = $clog2(NUM_CH),
  localparam int STRIDE  = GROUP * NUM_SETS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chanReq,
  input  sarb_strobe_t      strobe,
  input  logic [SET_W-1:0]  ownerSet,
  output logic              anyReq,
  output logic              heldReq,
  output logic [IDX_W-1:0]  grantIdx
);

  // Map (set, member) to a channel number
  function automatic logic [IDX_W-1:0] chanOf(input logic [SET_W-1:0] s,
                                               input logic [MEM_W-1:0] m);
    return IDX_W'((int'(m) / GROUP) * STRIDE + int'(s) * GROUP + int'(m) % GROUP);
  endfunction

  logic [MEMBERS-1:0] setReq  [NUM_SETS];
  logic [MEM_W-1:0]   pickMem [NUM_SETS];
  logic [NUM_SETS-1:0] setAny;
  logic [MEM_W-1:0]   rrPtr   [NUM_SETS];
  logic [SET_W-1:0]   selSet;
  logic [IDX_W-1:0]   grantIdxQ;
  logic [SET_W-1:0]   grantSetQ;
  logic [MEM_W-1:0]   grantMemQ;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    for (genvar m = 0; m < MEMBERS; m++) begin : g_mem
      assign setReq[s][m] = chanReq[(m / GROUP) * STRIDE + s * GROUP + m % GROUP];
    end
    assign setAny[s] = |setReq[s];

    // Rotating search starting at this set's pointer
    logic [MEM_W-1:0] pick;
    always_comb begin
      logic             found;
      logic [MEM_W-1:0] cand;
      pick  = '0;
      found = 1'b0;
      for (int k = 0; k < MEMBERS; k++) begin
        cand = rrPtr[s] + MEM_W'(k);
        if (!found && setReq[s][cand]) begin
          pick  = cand;
          found = 1'b1;
        end
      end
    end
    assign pickMem[s] = pick;
  end

  // Slot owner first, otherwise the lowest-numbered requesting set
  always_comb begin
    selSet = ownerSet;
    if (!setAny[ownerSet]) begin
      for (int s = NUM_SETS - 1; s >= 0; s--) begin
        if (setAny[s]) selSet = SET_W'(s);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantIdxQ <= '0;
      grantSetQ <= '0;
      grantMemQ <= '0;
      for (int s = 0; s < NUM_SETS; s++) rrPtr[s] <= '0;
    end else begin
      if (strobe.loadGrant) begin
        grantIdxQ <= chanOf(selSet, pickMem[selSet]);
        grantSetQ <= selSet;
        grantMemQ <= pickMem[selSet];
      end
      if (strobe.commitGrant) begin
        rrPtr[grantSetQ] <= grantMemQ + 1'b1;
      end
    end
  end

  assign anyReq   = |chanReq;
  assign heldReq  = chanReq[grantIdxQ];
  assign grantIdx = grantIdxQ;

  // R3: the slot owner wins whenever it requests
  p_owner_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadGrant && setAny[ownerSet]) |=> grantSetQ == $past(ownerSet));

  // R3: on fallback, no lower-numbered set was requesting
  p_fallback_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadGrant && !setAny[ownerSet]) |=>
      (($past(setAny) & ((NUM_SETS'(1) << grantSetQ) - NUM_SETS'(1))) == '0));

  // R4: the winning set actually had a request
  p_set_req_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadGrant |=> $past(setAny[selSet]));

endmodule

// File: rtl/slot_set_arbiter.sv
module slot_set_arbiter
  import sarb_pkg::*;
#(
  parameter int NUM_CH   = 32,
  parameter int NUM_SETS = 4,
  parameter int GROUP    = 4,
  localparam int IDX_W   = $clog2(NUM_CH),
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chanReq,
  input  logic              grantAccept,
  output logic [NUM_CH-1:0] grantVec,
  output logic [IDX_W-1:0]  grantIdx,
  output logic              grantValid
);

  sarb_strobe_t     strobe;
  logic             anyReq;
  logic             heldReq;
  logic [SET_W-1:0] ownerSet;

  sarb_ctrl #(.NUM_SETS(NUM_SETS)) ctrl_i (
    .clk(clk), .rstN(rstN), .anyReq(anyReq), .heldReq(heldReq),
    .grantAccept(grantAccept), .strobe(strobe), .grantValid(grantValid),
    .ownerSet(ownerSet)
  );

  sarb_path #(.NUM_CH(NUM_CH), .NUM_SETS(NUM_SETS), .GROUP(GROUP)) path_i (
    .clk(clk), .rstN(rstN), .chanReq(chanReq), .strobe(strobe),
    .ownerSet(ownerSet), .anyReq(anyReq), .heldReq(heldReq), .grantIdx(grantIdx)
  );

  always_comb begin
    grantVec = '0;
    if (grantValid) grantVec[grantIdx] = 1'b1;
  end

  // R9: one-hot grant that matches the valid flag
  p_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec) && ((grantVec != '0) == grantValid));

  // R5: a held grant keeps its channel while the request stays up
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !grantAccept && chanReq[grantIdx]) |=> grantValid && $stable(grantIdx));

  // R7: a withdrawn request loses the grant on the next clock
  p_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !grantAccept && !chanReq[grantIdx]) |=> !grantValid);

  // R1: a newly raised grant points at a channel that was requesting
  p_grant_req_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grantValid) |-> (($past(chanReq) & grantVec) != '0));

endmodule

// File: tb/slot_set_arbiter_tb_top.sv
`timescale 1ns/1ps
module slot_set_arbiter_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] chanReq = '0;
  logic        grantAccept = 1'b0;
  logic [31:0] grantVec;
  logic [4:0]  grantIdx;
  logic        grantValid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  // Model state
  int mSlot = 0;
  int mRr [4] = '{0, 0, 0, 0};
  int setTally [4] = '{0, 0, 0, 0};

  always #4 clk = ~clk;  // 125 MHz

  slot_set_arbiter dut_i (
    .clk(clk), .rstN(rstN), .chanReq(chanReq), .grantAccept(grantAccept),
    .grantVec(grantVec), .grantIdx(grantIdx), .grantValid(grantValid)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ownerOf(input int slot);
    if (slot % 2 == 0) return 0;
    if (slot % 4 == 1) return 1;
    if (slot == 3)     return 2;
    return 3;
  endfunction

  function automatic int chanAt(input int s, input int m);
    return (m / 4) * 16 + s * 4 + (m % 4);
  endfunction

  function automatic int expChan(input logic [31:0] r);
    int sel;
    bit has [4];
    for (int s = 0; s < 4; s++) begin
      has[s] = 0;
      for (int m = 0; m < 8; m++) if (r[chanAt(s, m)]) has[s] = 1;
    end
    sel = ownerOf(mSlot);
    if (!has[sel]) begin
      sel = -1;
      for (int s = 0; s < 4; s++) if (sel < 0 && has[s]) sel = s;
    end
    if (sel < 0) return -1;
    for (int k = 0; k < 8; k++) begin
      int m;
      m = (mRr[sel] + k) % 8;
      if (r[chanAt(sel, m)]) return chanAt(sel, m);
    end
    return -1;
  endfunction

  function automatic void commitModel(input int ch);
    int s;
    int m;
    s = (ch / 4) % 4;
    m = (ch / 16) * 4 + ch % 4;
    mRr[s] = (m + 1) % 8;
    mSlot = (mSlot + 1) % 8;
    setTally[s]++;
  endfunction

  // Called at a negedge with no grant held
  task automatic grantOnce(input logic [31:0] r, input string tag);
    int e;
    chanReq = r;
    e = expChan(r);
    @(negedge clk);
    chk({tag, " R10 valid"}, grantValid, 1);
    chk({tag, " idx"}, grantIdx, e);
    chk({tag, " R9 vec"}, grantVec, 64'(32'd1 << e));
    grantAccept = 1'b1;
    commitModel(e);
    @(negedge clk);
    grantAccept = 1'b0;
    chk({tag, " R6 release"}, grantValid, 0);
  endtask

  function automatic logic [31:0] lfsr(input logic [31:0] v);
    return v[0] ? ((v >> 1) ^ 32'hA300_0001) : (v >> 1);
  endfunction

  initial begin
    logic [31:0] a;
    logic [31:0] b;
    int e;
    int held;
    repeat (4) @(negedge clk);
    chk("R8 reset valid", grantValid, 0);
    chk("R8 reset vec", grantVec, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R8 idle after reset", grantValid, 0);

    // R8: first grant under full load is channel 0
    grantOnce(32'hFFFF_FFFF, "R8 first");
    chk("R8 first channel", grantIdx, 0);

    // R2: share of service over 32 grants under full load
    for (int i = 0; i < 4; i++) setTally[i] = 0;
    for (int i = 0; i < 32; i++) grantOnce(32'hFFFF_FFFF, "R2 full");
    chk("R2 set0 share", setTally[0], 16);
    chk("R2 set1 share", setTally[1], 8);
    chk("R2 set2 share", setTally[2], 4);
    chk("R2 set3 share", setTally[3], 4);

    // R4 and R1: only set 2 requesting, members rotate through both groups
    for (int i = 0; i < 16; i++) grantOnce(32'h0F00_0F00, "R4 set2 only");
    // R1: single channel of set 3 high, owner set absent
    grantOnce(32'h1000_0000, "R1 ch28");

    // R3: owner set idle, fallback picks lowest requesting set
    grantOnce(32'hF0F0_F0F0 & 32'h00F0_F000, "R3 fallback");
    a = 32'h1234_5678;
    b = 32'h9ABC_DEF1;
    for (int i = 0; i < 300; i++) begin
      a = lfsr(a);
      b = lfsr(lfsr(b));
      if ((a & b) != 0) grantOnce(a & b, "R3 sweep");
    end

    // R5: grant held stable without accept
    chanReq = 32'hFFFF_FFFF;
    e = expChan(chanReq);
    @(negedge clk);
    held = grantIdx;
    chk("R5 held idx", held, e);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R5 stable valid", grantValid, 1);
      chk("R5 stable idx", grantIdx, held);
    end
    grantAccept = 1'b1;
    commitModel(e);
    @(negedge clk);
    grantAccept = 1'b0;
    chk("R6 release after hold", grantValid, 0);

    // R7: withdraw the granted request, nothing advances
    chanReq = 32'hFFFF_FFFF;
    e = expChan(chanReq);
    @(negedge clk);
    chk("R7 granted", grantIdx, e);
    chanReq = 32'hFFFF_FFFF & ~(32'd1 << e);
    @(negedge clk);
    chk("R7 dropped", grantValid, 0);
    chanReq = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R7 regrant same", grantIdx, e);
    grantAccept = 1'b1;
    commitModel(e);
    @(negedge clk);
    grantAccept = 1'b0;

    // R6: accept while idle changes nothing
    chanReq = '0;
    @(negedge clk);
    grantAccept = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 idle accept valid", grantValid, 0);
    grantAccept = 1'b0;
    grantOnce(32'hFFFF_FFFF, "R6 after idle accept");
    grantOnce(32'h8000_0001, "R6 sparse");

    chanReq = '0;
    @(negedge clk);
    chk("R9 idle vec", grantVec, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule